// File: doc/BRIEF.md
# Three-Mode Boot Lock Controller

This block sits in a cartridge bank mapper and controls one upper ROM address line during the console's boot sequence. It has three modes: first-locked, second-locked and unlocked. In second-locked mode it forces the upper address line high, so the boot program reads a substitute logo. In the other two modes the line follows the CPU address bit.

The block counts low-to-high transitions of the CPU's top address bit to move through the modes. It also watches a chip-select line. A rising edge on that line means that one kind of boot program has written to work RAM. When this happens in first-locked mode, the block jumps straight to second-locked mode.

Both the top address bit and the chip select are synchronised to the system clock before edge detection. Once the block is unlocked, it stays unlocked until reset. Bank switching is not part of this block. The mode is reported on a status output.

Top module: `boot_lock_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the mode output reads first-locked. The mode encoding is 2'b00 first-locked, 2'b01 second-locked, 2'b10 unlocked.
- R2: In first-locked and unlocked modes, `ra7_out` equals `a7_in` in the same cycle, through a purely combinational path.
- R3: In second-locked mode, `ra7_out` is 1 whatever the value of `a7_in`.
- R4: In first-locked mode, the 48th rising edge of `a15_in` (STEP_COUNT) moves the mode to second-locked. After 47 edges the mode is still first-locked.
- R5: In second-locked mode, 48 further rising edges of `a15_in` move the mode to unlocked. After 47 edges the mode is still second-locked.
- R6: A rising edge of `cs_in` in first-locked mode moves the mode to second-locked and clears the edge count, so a full 48 further edges are needed to unlock.
- R7: A rising edge of `cs_in` in second-locked or unlocked mode has no effect on the mode.
- R8: Unlocked mode is left only by reset. Further `a15_in` or `cs_in` edges keep the mode unlocked.
- R9: An input rise that is driven before clock edge k takes effect on the mode at edge k+SYNC_STAGES. With the default of 2 stages, the mode still holds its old value after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a15_in | input | 1 | CPU top address bit, asynchronous |
| a7_in | input | 1 | CPU address bit 7 |
| cs_in | input | 1 | Work RAM chip select, asynchronous |
| ra7_out | output | 1 | ROM address bit 7 toward the ROM |
| mode_out | output | 2 | Current mode (00 first-locked, 01 second-locked, 10 unlocked) |

## Verification
The assertions assume that the mode only ever moves forward, and that `ra7_out` depends only on the mode and on `a7_in`. For that to hold, every pulse on `a15_in` and `cs_in` must last long enough for the synchroniser to see it. The stimulus therefore holds each pulse high for four clocks and low for four clocks. It never overlaps an `a15_in` pulse with a `cs_in` pulse, and it waits for the synchroniser latency before comparing against the bench's own mode and count model. Random sequences of pulses with random `a7_in` values are mixed with directed runs of exactly 47 and 48 edges, and with a chip-select edge in the middle of a count.

// File: rtl/boot_lock_ctrl.sv
module boot_lock_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int STEP_COUNT  = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a15_in,
  input  logic       a7_in,
  input  logic       cs_in,
  output logic       ra7_out,
  output logic [1:0] mode_out
);
  localparam int CNT_W = $clog2(STEP_COUNT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_COUNT - 1);
  localparam logic [1:0] M_FIRST  = 2'b00;
  localparam logic [1:0] M_SECOND = 2'b01;
  localparam logic [1:0] M_OPEN   = 2'b10;

  logic [SYNC_STAGES:0] a15_sh, cs_sh;
  logic [CNT_W-1:0]     cnt;
  logic [1:0]           mode;
  logic                 a15_rise, cs_rise;

  assign a15_rise = a15_sh[SYNC_STAGES-1] & ~a15_sh[SYNC_STAGES];
  assign cs_rise  = cs_sh[SYNC_STAGES-1]  & ~cs_sh[SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a15_sh <= '0;
      cs_sh  <= '0;
    end else begin
      a15_sh <= {a15_sh[SYNC_STAGES-1:0], a15_in};
      cs_sh  <= {cs_sh[SYNC_STAGES-1:0], cs_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_FIRST;
      cnt  <= '0;
    end else if (mode == M_FIRST && cs_rise) begin
      mode <= M_SECOND;
      cnt  <= '0;
    end else if (mode != M_OPEN && a15_rise) begin
      if (cnt == LAST) begin
        mode <= (mode == M_FIRST) ? M_SECOND : M_OPEN;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign ra7_out  = (mode == M_SECOND) ? 1'b1 : a7_in;
  assign mode_out = mode;
endmodule

module boot_lock_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       a7_in,
  input logic       ra7_out,
  input logic [1:0] mode_out
);
  AST_RA7_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out != 2'b01) |-> (ra7_out == a7_in)); // R2
  AST_RA7_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out == 2'b01) |-> ra7_out); // R3
  AST_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out == 2'b00) |=> (mode_out != 2'b10)); // R4
  AST_NO_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out == 2'b01) |=> (mode_out != 2'b00)); // R7
  AST_OPEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out == 2'b10) |=> (mode_out == 2'b10)); // R8
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mode_out)); // R1
endmodule

bind boot_lock_ctrl boot_lock_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .a7_in(a7_in), .ra7_out(ra7_out), .mode_out(mode_out)
);

// File: tb/boot_lock_ctrl_bench.sv
module boot_lock_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STEPS = 48;

  logic clk = 0, rst_n = 0, a15 = 0, a7 = 0, cs = 0;
  logic ra7;
  logic [1:0] mode;
  int checks = 0, fails = 0;
  int m_mode = 0, m_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_lock_ctrl u_boot_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .a15_in(a15), .a7_in(a7), .cs_in(cs),
    .ra7_out(ra7), .mode_out(mode)
  );

  function automatic logic exp_ra7(int md, logic a);
    return (md == 1) ? 1'b1 : a;
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_mode(string req, int exp);
    checks++;
    if (mode !== 2'(exp)) begin
      fails++;
      $display("FAIL %s mode got %0d expected %0d", req, mode, exp);
    end
  endtask

  task automatic chk_ra7(string req);
    logic e;
    e = exp_ra7(m_mode, a7);
    checks++;
    if (ra7 !== e) begin
      fails++;
      $display("FAIL %s ra7 got %0b expected %0b", req, ra7, e);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; a15 = 0; cs = 0;
    cyc(3);
    rst_n = 1;
    m_mode = 0; m_cnt = 0;
    cyc(1);
  endtask

  task automatic pulse_a15();
    a15 = 1; cyc(4); a15 = 0; cyc(4);
    if (m_mode < 2) begin
      m_cnt++;
      if (m_cnt == STEPS) begin m_mode++; m_cnt = 0; end
    end
  endtask

  task automatic pulse_cs();
    cs = 1; cyc(4); cs = 0; cyc(4);
    if (m_mode == 0) begin m_mode = 1; m_cnt = 0; end
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) pulse_a15();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0B07));
    cyc(1);
    chk_mode("R1 during reset", 0);
    do_reset();
    chk_mode("R1 after reset", 0);
    a7 = 1; #1; chk_ra7("R2 first-locked a7=1");
    a7 = 0; #1; chk_ra7("R2 first-locked a7=0");

    pulses(STEPS - 1);
    chk_mode("R4 after 47 edges", 0);
    a15 = 1;
    cyc(2);
    chk_mode("R9 not yet switched", 0);
    cyc(1);
    m_mode = 1; m_cnt = 0;
    chk_mode("R9 switched on third edge", 1);
    chk_mode("R4 after 48 edges", 1);
    cyc(1); a15 = 0; cyc(4);
    a7 = 0; #1; chk_ra7("R3 second-locked a7=0");

    pulse_cs(); pulse_cs();
    chk_mode("R7 cs ignored in second-locked", 1);
    pulses(STEPS - 1);
    chk_mode("R5 after 47 edges", 1);
    pulse_a15();
    chk_mode("R5 after 48 edges", 2);
    a7 = 0; #1; chk_ra7("R2 unlocked a7=0");
    a7 = 1; #1; chk_ra7("R2 unlocked a7=1");
    pulse_cs();
    chk_mode("R7 cs ignored in unlocked", 2);
    pulses(60);
    chk_mode("R8 unlocked stays", 2);

    do_reset();
    chk_mode("R1 re-reset", 0);
    pulses(20);
    pulse_cs();
    chk_mode("R6 cs shortcut", 1);
    pulses(STEPS - 1);
    chk_mode("R6 count cleared, 47 edges", 1);
    pulse_a15();
    chk_mode("R6 count cleared, 48 edges", 2);

    for (int ep = 0; ep < 4; ep++) begin
      do_reset();
      for (int op = 0; op < 140; op++) begin
        int r;
        r = int'($urandom_range(99));
        if (r < 88) pulse_a15();
        else if (r < 91) pulse_cs();
        else cyc(2);
        a7 = 1'($urandom);
        #1;
        chk_mode("R4/R5/R6/R7/R8 random", m_mode);
        chk_ra7("R2/R3 random");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule